// File: doc/BRIEF.md
# DMA Event and Interrupt Router

This block sits beside a multi-threaded DMA engine. It collects the "signal event N" requests that the engine's threads issue. There is one manager thread and a parameterised number of channel threads. Each accepted event goes to one of two places. It either becomes a wake-up flag that threads waiting on that event number can see and consume, or it becomes a level-sensitive interrupt line towards a host processor. A 32-bit enable register makes this choice separately for each event number.

Interrupt lines are sticky. Software lowers them by writing ones into a write-one-to-clear register. A separate fault interrupt follows the OR of the threads' fault flags. When several threads signal events in the same cycle, a fixed-priority arbiter accepts one request per cycle. The others stay held until they are accepted. Software reaches the enable register, the interrupt status and the clear register through a simple single-cycle register port.

Top module: `dma_event_router`

## Requirements
- R1: After a synchronous reset, `irq`, `fault_irq` and `reg_rdata` are all zero. The enable register is zero, and no wake-up flag is pending, so `wait_hit` stays zero for any waiter.
- R2: When an event N is accepted and enable bit N is 0, its wake-up flag is set from the next cycle on and `irq` is unchanged.
- R3: When an event N is accepted and enable bit N is 1, `irq[N]` is high from the next cycle on and no wake-up flag is set.
- R4: An `irq` bit stays high until a write to the clear register (address 2) with that bit at 1. A 0 bit in that write leaves the line as it is.
- R5: `wait_hit[i]` equals `wait_valid[i]` AND the wake-up flag of event `wait_num[i]`, in the same cycle. Every flag that produced a hit in a cycle is clear from the next cycle on.
- R6: In one cycle, a new event beats a clear of the same number. An irq set beats a clear write, and a wake-up set beats a consume.
- R7: `fault_irq` is high in the cycle after any `fault_in` bit is high, and low in the cycle after all are low.
- R8: Requester 0 is the manager and requesters 1 to NUM_CHAN are channels 0 upward. `ev_ready` is one-hot or zero, and it marks only the lowest-numbered valid requester. The others wait with `ev_ready` low.
- R9: Register map: address 0 is the enable register (read/write), address 1 is the irq status, and address 2 is the clear register, which reads as zero. Other addresses read as zero. `reg_rdata` carries the read one cycle after `reg_rd_en` and is zero when there was no read.
- R10: Writes to the status address (1) have no effect on `irq` or on its read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | NUM_EVENTS | Write data |
| reg_rdata | output | NUM_EVENTS | Read data, one cycle after the read |
| ev_valid | input | NUM_CHAN+1 | Event request per thread, bit 0 = manager |
| ev_num | input | (NUM_CHAN+1)*EV_W | Event number per thread, packed |
| ev_ready | output | NUM_CHAN+1 | Request accepted this cycle |
| wait_valid | input | NUM_CHAN+1 | Thread is waiting for an event |
| wait_num | input | (NUM_CHAN+1)*EV_W | Event number each thread waits on |
| wait_hit | output | NUM_CHAN+1 | Awaited event is pending; consumed this cycle |
| fault_in | input | NUM_CHAN+1 | Per-thread fault flag |
| fault_irq | output | 1 | Fault interrupt |
| irq | output | NUM_EVENTS | Sticky event interrupt lines |

## Verification
Directed sequences put the routing in both states of the enable bit for the same thread and number. This separates the wake-up path from the interrupt path. Targeted collisions apply next:
- a set and a clear of the same bit in one cycle;
- a set and a consume of the same flag in one cycle;
- several threads requesting at once, including the manager.

These show the priority rules. Long random runs follow, with event and wait numbers confined to a small range so that threads often collide on one number. They mix random enable masks, clears, status writes and fault patterns, and a bench model predicts every output in every cycle.

// File: rtl/dma_evr_pkg.sv
package dma_evr_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [7:0] a);
    case (a)
      8'd0:    return SEL_ENABLE;
      8'd1:    return SEL_STATUS;
      8'd2:    return SEL_CLEAR;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dma_evr_arbiter.sv
module dma_evr_arbiter #(
  parameter int NREQ = 9,
  parameter int EV_W = 5
) (
  input  logic [NREQ-1:0]      req,
  input  logic [NREQ*EV_W-1:0] num_in,
  output logic [NREQ-1:0]      grant,
  output logic                 any,
  output logic [EV_W-1:0]      num_sel
);

  logic [NREQ:0] blocked;

  assign blocked[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NREQ; gi++) begin : g_pri
      assign grant[gi]     = req[gi] & ~blocked[gi];
      assign blocked[gi+1] = blocked[gi] | req[gi];
    end
  endgenerate

  assign any = blocked[NREQ];

  always_comb begin
    num_sel = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) num_sel = num_in[i*EV_W +: EV_W];
    end
  end

endmodule

// File: rtl/dma_evr_regs.sv
module dma_evr_regs
  import dma_evr_pkg::*;
#(
  parameter int NUM_EVENTS = 32,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_EVENTS-1:0] wdata,
  input  logic [NUM_EVENTS-1:0] irq_state,
  output logic [NUM_EVENTS-1:0] inten,
  output logic [NUM_EVENTS-1:0] clr_mask,
  output logic [NUM_EVENTS-1:0] rdata
);

  reg_sel_e sel;

  assign sel      = decode_sel(8'(addr));
  assign clr_mask = (wr_en && sel == SEL_CLEAR) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      inten <= '0;
      rdata <= '0;
    end else begin
      if (wr_en && sel == SEL_ENABLE) inten <= wdata;
      if (rd_en) begin
        case (sel)
          SEL_ENABLE: rdata <= inten;
          SEL_STATUS: rdata <= irq_state;
          default:    rdata <= '0;
        endcase
      end else begin
        rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/dma_evr_state.sv
module dma_evr_state #(
  parameter int NUM_EVENTS = 32,
  parameter int NREQ       = 9,
  parameter int EV_W       = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_valid,
  input  logic [EV_W-1:0]       set_num,
  input  logic [NUM_EVENTS-1:0] inten,
  input  logic [NUM_EVENTS-1:0] clr_mask,
  input  logic [NREQ-1:0]       wait_valid,
  input  logic [NREQ*EV_W-1:0]  wait_num,
  output logic [NREQ-1:0]       wait_hit,
  output logic [NUM_EVENTS-1:0] irq
);

  logic [NUM_EVENTS-1:0] pending_q;
  logic [NUM_EVENTS-1:0] onehot;
  logic [NUM_EVENTS-1:0] set_irq;
  logic [NUM_EVENTS-1:0] set_pend;
  logic [NUM_EVENTS-1:0] consume;

  assign onehot   = NUM_EVENTS'(1) << set_num;
  assign set_irq  = (set_valid &&  inten[set_num]) ? onehot : '0;
  assign set_pend = (set_valid && !inten[set_num]) ? onehot : '0;

  genvar gi;
  generate
    for (gi = 0; gi < NREQ; gi++) begin : g_wait
      assign wait_hit[gi] = wait_valid[gi] & pending_q[wait_num[gi*EV_W +: EV_W]];
    end
  endgenerate

  always_comb begin
    consume = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (wait_hit[i]) consume[wait_num[i*EV_W +: EV_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= '0;
      pending_q <= '0;
    end else begin
      irq       <= (irq & ~clr_mask) | set_irq;
      pending_q <= (pending_q & ~consume) | set_pend;
    end
  end

endmodule

// File: rtl/dma_event_router.sv
module dma_event_router #(
  parameter int NUM_CHAN   = 8,
  parameter int NUM_EVENTS = 32,
  parameter int ADDR_W     = 4,
  localparam int NREQ      = NUM_CHAN + 1,
  localparam int EV_W      = $clog2(NUM_EVENTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [NUM_EVENTS-1:0] reg_wdata,
  output logic [NUM_EVENTS-1:0] reg_rdata,
  input  logic [NREQ-1:0]       ev_valid,
  input  logic [NREQ*EV_W-1:0]  ev_num,
  output logic [NREQ-1:0]       ev_ready,
  input  logic [NREQ-1:0]       wait_valid,
  input  logic [NREQ*EV_W-1:0]  wait_num,
  output logic [NREQ-1:0]       wait_hit,
  input  logic [NREQ-1:0]       fault_in,
  output logic                  fault_irq,
  output logic [NUM_EVENTS-1:0] irq
);

  logic                  acc_any;
  logic [EV_W-1:0]       acc_num;
  logic [NUM_EVENTS-1:0] inten_q;
  logic [NUM_EVENTS-1:0] clr_mask;

  dma_evr_arbiter #(.NREQ(NREQ), .EV_W(EV_W)) u_arb (
    .req     (ev_valid),
    .num_in  (ev_num),
    .grant   (ev_ready),
    .any     (acc_any),
    .num_sel (acc_num)
  );

  dma_evr_regs #(.NUM_EVENTS(NUM_EVENTS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr_en),
    .rd_en     (reg_rd_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .irq_state (irq),
    .inten     (inten_q),
    .clr_mask  (clr_mask),
    .rdata     (reg_rdata)
  );

  dma_evr_state #(.NUM_EVENTS(NUM_EVENTS), .NREQ(NREQ), .EV_W(EV_W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .set_valid  (acc_any),
    .set_num    (acc_num),
    .inten      (inten_q),
    .clr_mask   (clr_mask),
    .wait_valid (wait_valid),
    .wait_num   (wait_num),
    .wait_hit   (wait_hit),
    .irq        (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) fault_irq <= 1'b0;
    else     fault_irq <= |fault_in;
  end

endmodule

// File: rtl/dma_event_router_chk.sv
module dma_event_router_chk #(
  parameter int NUM_CHAN   = 8,
  parameter int NUM_EVENTS = 32,
  parameter int ADDR_W     = 4,
  localparam int NREQ      = NUM_CHAN + 1,
  localparam int EV_W      = $clog2(NUM_EVENTS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_wr_en,
  input logic                  reg_rd_en,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [NUM_EVENTS-1:0] reg_wdata,
  input logic [NUM_EVENTS-1:0] reg_rdata,
  input logic [NREQ-1:0]       ev_valid,
  input logic [NREQ*EV_W-1:0]  ev_num,
  input logic [NREQ-1:0]       ev_ready,
  input logic [NREQ-1:0]       wait_valid,
  input logic [NREQ-1:0]       wait_hit,
  input logic [NREQ-1:0]       fault_in,
  input logic                  fault_irq,
  input logic [NUM_EVENTS-1:0] irq,
  input logic [NUM_EVENTS-1:0] inten
);

  logic                  acc;
  logic [EV_W-1:0]       acc_num;
  logic [NUM_EVENTS-1:0] clr_vec;

  always_comb begin
    acc     = |ev_ready;
    acc_num = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (ev_ready[i]) acc_num = ev_num[i*EV_W +: EV_W];
    end
  end

  assign clr_vec = (reg_wr_en && reg_addr == ADDR_W'(2)) ? reg_wdata : '0;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ev_ready)); // R8
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (ev_ready & ~ev_valid) == '0); // R8
  AST_MANAGER_FIRST: assert property (@(posedge clk) disable iff (rst)
    ev_valid[0] |-> ev_ready[0]); // R8
  AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (acc && inten[acc_num]) |=> irq[$past(acc_num)]); // R3
  AST_INTERNAL_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (acc && !inten[acc_num] && !clr_vec[acc_num])
      |=> irq[$past(acc_num)] == $past(irq[acc_num])); // R2
  AST_IRQ_FALL_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (($past(irq) & ~irq) & ~$past(clr_vec)) == '0); // R4
  AST_FAULT_UP: assert property (@(posedge clk) disable iff (rst)
    (|fault_in) |=> fault_irq); // R7
  AST_FAULT_DOWN: assert property (@(posedge clk) disable iff (rst)
    !(|fault_in) |=> !fault_irq); // R7
  AST_HIT_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
    (wait_hit & ~wait_valid) == '0); // R5
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr == ADDR_W'(2)) |=> reg_rdata == '0); // R9
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr == ADDR_W'(1)) |=> reg_rdata == $past(irq)); // R9

endmodule

bind dma_event_router dma_event_router_chk #(
  .NUM_CHAN(NUM_CHAN), .NUM_EVENTS(NUM_EVENTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr_en  (reg_wr_en),
  .reg_rd_en  (reg_rd_en),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .ev_valid   (ev_valid),
  .ev_num     (ev_num),
  .ev_ready   (ev_ready),
  .wait_valid (wait_valid),
  .wait_hit   (wait_hit),
  .fault_in   (fault_in),
  .fault_irq  (fault_irq),
  .irq        (irq),
  .inten      (inten_q)
);

// File: tb/dma_event_router_test.sv
`timescale 1ns/1ps
module dma_event_router_test;

  localparam int NUM_CHAN   = 8;
  localparam int NUM_EVENTS = 32;
  localparam int ADDR_W     = 4;
  localparam int NREQ       = NUM_CHAN + 1;
  localparam int EV_W       = 5;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  reg_wr_en = 1'b0;
  logic                  reg_rd_en = 1'b0;
  logic [ADDR_W-1:0]     reg_addr = '0;
  logic [NUM_EVENTS-1:0] reg_wdata = '0;
  logic [NUM_EVENTS-1:0] reg_rdata;
  logic [NREQ-1:0]       ev_valid = '0;
  logic [NREQ*EV_W-1:0]  ev_num = '0;
  logic [NREQ-1:0]       ev_ready;
  logic [NREQ-1:0]       wait_valid = '0;
  logic [NREQ*EV_W-1:0]  wait_num = '0;
  logic [NREQ-1:0]       wait_hit;
  logic [NREQ-1:0]       fault_in = '0;
  logic                  fault_irq;
  logic [NUM_EVENTS-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NUM_EVENTS-1:0] m_inten = '0, m_irq = '0, m_pend = '0, m_rdata = '0;
  logic                  m_fault = 1'b0;

  always #10 clk = ~clk;

  dma_event_router #(.NUM_CHAN(NUM_CHAN), .NUM_EVENTS(NUM_EVENTS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_valid(ev_valid), .ev_num(ev_num), .ev_ready(ev_ready),
    .wait_valid(wait_valid), .wait_num(wait_num), .wait_hit(wait_hit),
    .fault_in(fault_in), .fault_irq(fault_irq), .irq(irq)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NREQ-1:0] lowest(input logic [NREQ-1:0] v);
    for (int i = 0; i < NREQ; i++) if (v[i]) return NREQ'(1) << i;
    return '0;
  endfunction

  function automatic logic [EV_W-1:0] pick(input logic [NREQ*EV_W-1:0] nums, input int i);
    return nums[i*EV_W +: EV_W];
  endfunction

  task automatic idle();
    reg_wr_en = 0; reg_rd_en = 0; reg_addr = '0; reg_wdata = '0;
    ev_valid = '0; wait_valid = '0;
  endtask

  // Inputs are set after a falling edge; one call covers one clock cycle.
  task automatic step(input string t_irq, input string t_hit, input string t_rd);
    logic [NREQ-1:0]       e_rdy, e_hit;
    logic [NUM_EVENTS-1:0] cons, clr, s_irq, s_pend;
    logic [EV_W-1:0]       n;
    #2;
    e_rdy = lowest(ev_valid);
    check(ev_ready == e_rdy, "R8 ready", 32'(ev_ready), 32'(e_rdy));
    e_hit = '0; cons = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (wait_valid[i] && m_pend[pick(wait_num, i)]) begin
        e_hit[i] = 1'b1;
        cons[pick(wait_num, i)] = 1'b1;
      end
    end
    check(wait_hit == e_hit, t_hit, 32'(wait_hit), 32'(e_hit));
    clr = (reg_wr_en && reg_addr == 2) ? reg_wdata : '0;
    s_irq = '0; s_pend = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (e_rdy[i]) begin
        n = pick(ev_num, i);
        if (m_inten[n]) s_irq[n] = 1'b1; else s_pend[n] = 1'b1;
      end
    end
    if (reg_rd_en) m_rdata = (reg_addr == 0) ? m_inten : (reg_addr == 1) ? m_irq : '0;
    else           m_rdata = '0;
    if (reg_wr_en && reg_addr == 0) m_inten = reg_wdata;
    m_irq   = (m_irq & ~clr) | s_irq;
    m_pend  = (m_pend & ~cons) | s_pend;
    m_fault = |fault_in;
    @(posedge clk); #1;
    check(irq == m_irq, t_irq, irq, m_irq);
    check(fault_irq == m_fault, "R7 fault_irq", 32'(fault_irq), 32'(m_fault));
    check(reg_rdata == m_rdata, t_rd, reg_rdata, m_rdata);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    for (int i = 0; i < NREQ; i++) wait_num[i*EV_W +: EV_W] = EV_W'(i);
    wait_valid = '1;
    #2;
    check(irq == '0, "R1 irq", irq, 0);
    check(fault_irq == 1'b0, "R1 fault_irq", 32'(fault_irq), 0);
    check(reg_rdata == '0, "R1 rdata", reg_rdata, 0);
    check(wait_hit == '0, "R1 wait_hit", 32'(wait_hit), 0);
    @(negedge clk); idle();
    // Enable events 4..7 and read back
    reg_wr_en = 1; reg_addr = 0; reg_wdata = 32'h0000_00F0;
    step("R9 irq", "R5 hit", "R9 rdata"); idle();
    reg_rd_en = 1; reg_addr = 0;
    step("R9 irq", "R5 hit", "R9 enable read"); idle();
    // R3: enabled event 5 from channel 2 (requester 3)
    ev_valid[3] = 1; ev_num[3*EV_W +: EV_W] = 5;
    step("R3 irq set", "R5 hit", "R9 rdata"); idle();
    // R2: disabled event 2 from the manager, then two waiters
    ev_valid[0] = 1; ev_num[0 +: EV_W] = 2;
    step("R2 irq unchanged", "R5 hit", "R9 rdata"); idle();
    wait_valid[1] = 1; wait_num[1*EV_W +: EV_W] = 2;
    wait_valid[4] = 1; wait_num[4*EV_W +: EV_W] = 2;
    step("R2 irq", "R2 wake hit", "R9 rdata");
    step("R5 irq", "R5 consumed", "R9 rdata"); idle();
    // R4: clear with zero mask, then with bit 5
    reg_wr_en = 1; reg_addr = 2; reg_wdata = 32'h0;
    step("R4 zero clear holds", "R5 hit", "R9 rdata");
    reg_wdata = 32'h20;
    step("R4 clear lowers", "R5 hit", "R9 rdata"); idle();
    // R6: set and clear of bit 6 in one cycle
    ev_valid[2] = 1; ev_num[2*EV_W +: EV_W] = 6;
    reg_wr_en = 1; reg_addr = 2; reg_wdata = 32'h40;
    step("R6 set beats clear", "R5 hit", "R9 rdata"); idle();
    // R6: wake-up set beats consume on event 1
    ev_valid[1] = 1; ev_num[1*EV_W +: EV_W] = 1;
    step("R2 irq", "R5 hit", "R9 rdata"); idle();
    ev_valid[1] = 1; ev_num[1*EV_W +: EV_W] = 1;
    wait_valid[6] = 1; wait_num[6*EV_W +: EV_W] = 1;
    step("R6 irq", "R5 hit", "R9 rdata"); idle();
    wait_valid[6] = 1; wait_num[6*EV_W +: EV_W] = 1;
    step("R6 irq", "R6 set beats consume", "R9 rdata"); idle();
    // R8: several requesters
    ev_valid = 9'b1_0110_0000;
    for (int i = 0; i < NREQ; i++) ev_num[i*EV_W +: EV_W] = EV_W'(10 + i);
    step("R8 irq", "R5 hit", "R9 rdata");
    ev_valid = 9'b1_0100_0000;
    step("R8 irq", "R5 hit", "R9 rdata"); idle();
    // R10: write to status is ignored
    reg_wr_en = 1; reg_addr = 1; reg_wdata = '1;
    step("R10 irq", "R5 hit", "R9 rdata"); idle();
    reg_rd_en = 1; reg_addr = 1;
    step("R10 irq", "R5 hit", "R10 status read"); idle();
    reg_rd_en = 1; reg_addr = 2;
    step("R9 irq", "R5 hit", "R9 clear reads zero");
    reg_addr = 3;
    step("R9 irq", "R5 hit", "R9 unmapped reads zero"); idle();
    // R7: fault on and off
    fault_in[7] = 1;
    step("R7 irq", "R5 hit", "R9 rdata");
    fault_in = '0;
    step("R7 irq", "R5 hit", "R9 rdata");
    // Random phase
    for (int c = 0; c < 4000; c++) begin
      idle();
      for (int i = 0; i < NREQ; i++) begin
        ev_valid[i]   = ($urandom_range(0, 3) == 0);
        ev_num[i*EV_W +: EV_W]   = ($urandom_range(0, 9) == 0) ? EV_W'($urandom) : EV_W'($urandom_range(0, 7));
        wait_valid[i] = ($urandom_range(0, 2) == 0);
        wait_num[i*EV_W +: EV_W] = EV_W'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 3) == 0) begin
        reg_wr_en = 1; reg_addr = ADDR_W'($urandom_range(0, 3));
        reg_wdata = $urandom;
      end
      reg_rd_en = ($urandom_range(0, 2) == 0);
      if (!reg_wr_en) reg_addr = ADDR_W'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) fault_in = NREQ'($urandom) & NREQ'($urandom);
      step("R4 random irq", "R5 random hit", "R9 random read");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule